// File: doc/BRIEF.md
# Paged I/O Address Translation Lookup

This block turns a device bus address into a physical page base by indexing a flat table of 64-bit page entries, one entry per I/O page. A request carries an address and the kind of access the device wants (read or write). One cycle after it is accepted, the block answers with four values: the page-aligned I/O address, the translated page base, the mask of in-page offset bits, and the permission taken from the entry. It also raises a fault flag when the requested access is not allowed.

Two configuration inputs set the page size and the window. The page size is given as a shift amount, and the window is given as a count of valid entries. The table is held on chip. A separate update engine fills it through a simple write port. An address whose page index falls outside the window does not cause a bus error. It returns a fixed answer: zero addresses, a mask of all ones and no permission. A count of zero switches the whole window off.

Top module: `io_page_xlate`

## Requirements
- R1: After reset, rsp_valid is 0 and req_ready is 1. Every table entry reads as zero, so an in-window lookup returns translated base 0, permission 0 and fault 1.
- R2: The permission output equals bits [1:0] of the selected entry for an in-window lookup. The codes are 0 = none, 1 = read only, 2 = write only, 3 = read and write.
- R3: With page mask M = all-ones shifted left by the effective shift, an in-window lookup returns rsp_iova = addr & M, rsp_xlate = entry & M and rsp_mask = ~M.
- R4: The page index is addr shifted right by the effective shift. It is in the window only when it is less than the effective count. Otherwise the response is rsp_iova 0, rsp_xlate 0, rsp_mask all ones, rsp_perm 0 and rsp_fault 1.
- R5: With cfg_entry_count equal to 0, every lookup returns the out-of-window response of R4.
- R6: rsp_fault is 1 when req_write is 0 and permission bit 0 is clear, or when req_write is 1 and permission bit 1 is clear. Otherwise it is 0.
- R7: A cfg_page_shift below 12 acts as 12, and a value above 24 acts as 24.
- R8: A cfg_entry_count above the table depth acts as the table depth.
- R9: A request is accepted on a clock edge where req_valid and req_ready are both 1, and its response is shown with rsp_valid in the next cycle. req_ready is 0 only while a response is waiting with rsp_ready low, and the response is held stable during that time.
- R10: A lookup accepted on the same edge as a table write to its entry returns the entry's old contents. Lookups accepted on later edges see the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_page_shift | input | 5 | Page size as log2 of bytes, clamped to 12..24 |
| cfg_entry_count | input | 7 | Number of valid entries in the window, clamped to the table depth |
| tbl_wr_en | input | 1 | Table write strobe from the update engine |
| tbl_wr_idx | input | 6 | Table entry to write |
| tbl_wr_data | input | 64 | New entry value |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 64 | Device bus address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_iova | output | 64 | Page-aligned I/O address |
| rsp_xlate | output | 64 | Translated page base |
| rsp_mask | output | 64 | In-page offset mask |
| rsp_perm | output | 2 | Permission code |
| rsp_fault | output | 1 | Requested access not permitted |

## Verification
Lookups are made against a preloaded table that holds all four permission codes, with each code tried under both read and write. This separates the permission decode from the fault rule. The addresses are placed at the first and last in-window index and just past the window edge, under a reduced count, a zero count and an oversized count, to show where the bounds compare flips. Page shifts of 12 and 16, plus out-of-range shift values, show whether mask generation follows the shift and where it clamps. Directed sequences cover a back-pressured response, a write and lookup to the same entry on the same edge, and the clearing of the table by reset.

// File: rtl/io_page_xlate_pkg.sv
package io_page_xlate_pkg;

  // Legal page shift range; out-of-range configuration is clamped to it.
  localparam int unsigned PSHIFT_MIN = 12;
  localparam int unsigned PSHIFT_MAX = 24;
  localparam int unsigned SHIFT_W    = 5;

  // Permission code held in the two low bits of every page entry.
  typedef enum logic [1:0] {
    PERM_NONE = 2'd0,
    PERM_RD   = 2'd1,
    PERM_WR   = 2'd2,
    PERM_RW   = 2'd3
  } perm_e;

  // True when the requested access kind is not granted by the code.
  function automatic logic access_denied(input logic [1:0] code, input logic is_write);
    return is_write ? ~code[1] : ~code[0];
  endfunction

endpackage

// File: rtl/io_page_xlate_cfg.sv
module io_page_xlate_cfg
  import io_page_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input  logic [SHIFT_W-1:0] cfg_page_shift,
  input  logic [CNT_W-1:0]   cfg_entry_count,
  output logic [SHIFT_W-1:0] shift_eff,
  output logic [ADDR_W-1:0]  page_mask,
  output logic [CNT_W-1:0]   count_eff
);

  // Clamp the page shift into the supported range.
  always_comb begin
    if (cfg_page_shift < SHIFT_W'(PSHIFT_MIN)) begin
      shift_eff = SHIFT_W'(PSHIFT_MIN);
    end else if (cfg_page_shift > SHIFT_W'(PSHIFT_MAX)) begin
      shift_eff = SHIFT_W'(PSHIFT_MAX);
    end else begin
      shift_eff = cfg_page_shift;
    end
  end

  // Upper address bits that select a page.
  assign page_mask = {ADDR_W{1'b1}} << shift_eff;

  // The window can never reach past the physical table.
  assign count_eff = (cfg_entry_count > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : cfg_entry_count;

endmodule

// File: rtl/io_page_xlate_table.sv
module io_page_xlate_table #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_data
);

  logic [ADDR_W-1:0] entry_q [DEPTH];

  // One register per entry; reset clears the table to "no access".
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
    logic hit_en;
    assign hit_en = wr_en && (wr_idx == IDX_W'(gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        entry_q[gi] <= '0;
      end else if (hit_en) begin
        entry_q[gi] <= wr_data;
      end
    end
  end

  // Combinational read: a same-edge write is not yet visible.
  assign rd_data = entry_q[rd_idx];

endmodule

// File: rtl/io_page_xlate_core.sv
module io_page_xlate_core
  import io_page_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               is_write,
  input  logic [SHIFT_W-1:0] shift_eff,
  input  logic [ADDR_W-1:0]  page_mask,
  input  logic [CNT_W-1:0]   count_eff,
  output logic [IDX_W-1:0]   rd_idx,
  input  logic [ADDR_W-1:0]  entry,
  output logic [ADDR_W-1:0]  iova,
  output logic [ADDR_W-1:0]  xlate,
  output logic [ADDR_W-1:0]  mask,
  output logic [1:0]         perm,
  output logic               fault
);

  logic [ADDR_W-1:0] page_idx;
  logic              in_window;

  // Full-width index so high address bits cannot alias into the window.
  assign page_idx  = addr >> shift_eff;
  assign in_window = page_idx < ADDR_W'(count_eff);
  assign rd_idx    = page_idx[IDX_W-1:0];

  always_comb begin
    if (in_window) begin
      iova  = addr & page_mask;
      xlate = entry & page_mask;
      mask  = ~page_mask;
      perm  = entry[1:0];
      fault = access_denied(entry[1:0], is_write);
    end else begin
      iova  = '0;
      xlate = '0;
      mask  = '1;
      perm  = PERM_NONE;
      fault = 1'b1;
    end
  end

endmodule

// File: rtl/io_page_xlate.sv
module io_page_xlate
  import io_page_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SHIFT_W-1:0] cfg_page_shift,
  input  logic [CNT_W-1:0]   cfg_entry_count,
  input  logic               tbl_wr_en,
  input  logic [IDX_W-1:0]   tbl_wr_idx,
  input  logic [ADDR_W-1:0]  tbl_wr_data,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_write,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [ADDR_W-1:0]  rsp_iova,
  output logic [ADDR_W-1:0]  rsp_xlate,
  output logic [ADDR_W-1:0]  rsp_mask,
  output logic [1:0]         rsp_perm,
  output logic               rsp_fault
);

  logic [SHIFT_W-1:0] shift_eff;
  logic [ADDR_W-1:0]  page_mask;
  logic [CNT_W-1:0]   count_eff;
  logic [IDX_W-1:0]   rd_idx;
  logic [ADDR_W-1:0]  rd_entry;
  logic [ADDR_W-1:0]  c_iova, c_xlate, c_mask;
  logic [1:0]         c_perm;
  logic               c_fault;

  io_page_xlate_cfg #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) cfg_i (
    .cfg_page_shift (cfg_page_shift),
    .cfg_entry_count(cfg_entry_count),
    .shift_eff      (shift_eff),
    .page_mask      (page_mask),
    .count_eff      (count_eff)
  );

  io_page_xlate_table #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) table_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (tbl_wr_en),
    .wr_idx (tbl_wr_idx),
    .wr_data(tbl_wr_data),
    .rd_idx (rd_idx),
    .rd_data(rd_entry)
  );

  io_page_xlate_core #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) core_i (
    .addr     (req_addr),
    .is_write (req_write),
    .shift_eff(shift_eff),
    .page_mask(page_mask),
    .count_eff(count_eff),
    .rd_idx   (rd_idx),
    .entry    (rd_entry),
    .iova     (c_iova),
    .xlate    (c_xlate),
    .mask     (c_mask),
    .perm     (c_perm),
    .fault    (c_fault)
  );

  // Output stage: one response register with back-pressure.
  logic              valid_q, valid_d;
  logic              accept;
  logic [ADDR_W-1:0] iova_q, xlate_q, mask_q;
  logic [1:0]        perm_q;
  logic              fault_q;

  assign req_ready = !valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_comb begin
    if (accept) begin
      valid_d = 1'b1;
    end else if (rsp_ready) begin
      valid_d = 1'b0;
    end else begin
      valid_d = valid_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iova_q  <= '0;
      xlate_q <= '0;
      mask_q  <= '0;
      perm_q  <= PERM_NONE;
      fault_q <= 1'b0;
    end else if (accept) begin
      iova_q  <= c_iova;
      xlate_q <= c_xlate;
      mask_q  <= c_mask;
      perm_q  <= c_perm;
      fault_q <= c_fault;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_iova  = iova_q;
  assign rsp_xlate = xlate_q;
  assign rsp_mask  = mask_q;
  assign rsp_perm  = perm_q;
  assign rsp_fault = fault_q;

endmodule

// File: rtl/io_page_xlate_chk.sv
module io_page_xlate_chk
  import io_page_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned CNT_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [CNT_W-1:0]  cfg_entry_count,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [ADDR_W-1:0] rsp_iova,
  input logic [ADDR_W-1:0] rsp_xlate,
  input logic [ADDR_W-1:0] rsp_mask,
  input logic [1:0]        rsp_perm,
  input logic              rsp_fault
);

  AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid); // R9

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_iova) && $stable(rsp_xlate)
      && $stable(rsp_mask) && $stable(rsp_perm) && $stable(rsp_fault)); // R9

  AST_READY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready); // R9

  AST_ALIGNED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_iova & rsp_mask) == '0) && ((rsp_xlate & rsp_mask) == '0)); // R3

  AST_OUT_OF_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_mask == '1) |-> (rsp_iova == '0) && (rsp_xlate == '0)
      && (rsp_perm == PERM_NONE) && rsp_fault); // R4

  AST_NO_PERM_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_perm == PERM_NONE) |-> rsp_fault); // R6

  AST_FULL_PERM_OK: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_perm == PERM_RW) |-> !rsp_fault); // R6

  AST_MASK_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_mask != '1) |-> ($countones(rsp_mask) >= PSHIFT_MIN)
      && ($countones(rsp_mask) <= PSHIFT_MAX)); // R7

  AST_EMPTY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (cfg_entry_count == '0) |=> (rsp_mask == '1)); // R5

endmodule

bind io_page_xlate io_page_xlate_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .cfg_entry_count(cfg_entry_count),
  .rsp_valid      (rsp_valid),
  .rsp_ready      (rsp_ready),
  .rsp_iova       (rsp_iova),
  .rsp_xlate      (rsp_xlate),
  .rsp_mask       (rsp_mask),
  .rsp_perm       (rsp_perm),
  .rsp_fault      (rsp_fault)
);

// File: tb/io_page_xlate_tb_top.sv
module io_page_xlate_tb_top;

  localparam int AW = 64;
  localparam int CW = 7;
  localparam int IW = 6;
  localparam int SW = 5;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] M12  = 64'h0000_0000_0000_0FFF;
  localparam logic [63:0] M16  = 64'h0000_0000_0000_FFFF;
  localparam logic [63:0] M24  = 64'h0000_0000_00FF_FFFF;

  typedef struct packed {
    logic [4:0]  shift;
    logic [6:0]  count;
    logic [63:0] addr;
    logic        wr;
    logic [63:0] iova;
    logic [63:0] xlate;
    logic [63:0] mask;
    logic [1:0]  perm;
    logic        fault;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{5'd12, 7'd64,  64'h0ABC,       1'b0, 64'h0,        64'h1234_5000,  M12,  2'd3, 1'b0, 8'd3},  // R3 R2 rw read
    '{5'd12, 7'd64,  64'h1FFF,       1'b1, 64'h1000,     64'hABCD_E000,  M12,  2'd1, 1'b1, 8'd6},  // R6 ro write
    '{5'd12, 7'd64,  64'h1234,       1'b0, 64'h1000,     64'hABCD_E000,  M12,  2'd1, 1'b0, 8'd2},  // R2 ro read
    '{5'd12, 7'd64,  64'h2010,       1'b0, 64'h2000,     64'h0055_5000,  M12,  2'd2, 1'b1, 8'd6},  // R6 wo read
    '{5'd12, 7'd64,  64'h2010,       1'b1, 64'h2000,     64'h0055_5000,  M12,  2'd2, 1'b0, 8'd6},  // R6 wo write
    '{5'd12, 7'd64,  64'h3000,       1'b0, 64'h3000,     64'h0077_7000,  M12,  2'd0, 1'b1, 8'd2},  // R2 none
    '{5'd12, 7'd64,  64'h3_FFFF,     1'b0, 64'h3_F000,   64'hFFFF_FFFF_FFFF_F000, M12, 2'd3, 1'b0, 8'd3}, // R3 last entry
    '{5'd12, 7'd64,  64'h4_0000,     1'b0, 64'h0,        64'h0,          ONES, 2'd0, 1'b1, 8'd4},  // R4 just past
    '{5'd12, 7'd4,   64'h3000,       1'b1, 64'h3000,     64'h0077_7000,  M12,  2'd0, 1'b1, 8'd4},  // R4 last in window
    '{5'd12, 7'd4,   64'h4000,       1'b0, 64'h0,        64'h0,          ONES, 2'd0, 1'b1, 8'd4},  // R4 first outside
    '{5'd12, 7'd0,   64'h0,          1'b0, 64'h0,        64'h0,          ONES, 2'd0, 1'b1, 8'd5},  // R5 zero count
    '{5'd16, 7'd64,  64'h2_3456,     1'b0, 64'h2_0000,   64'h0055_0000,  M16,  2'd2, 1'b1, 8'd3},  // R3 shift 16
    '{5'd4,  7'd64,  64'h1234,       1'b0, 64'h1000,     64'hABCD_E000,  M12,  2'd1, 1'b0, 8'd7},  // R7 low clamp
    '{5'd31, 7'd64,  64'hFF_FFFF,    1'b0, 64'h0,        64'h1200_0000,  M24,  2'd3, 1'b0, 8'd7},  // R7 high clamp
    '{5'd24, 7'd64,  64'h100_0000,   1'b1, 64'h100_0000, 64'hAB00_0000,  M24,  2'd1, 1'b1, 8'd7},  // R7 shift 24
    '{5'd12, 7'd100, 64'h4_0000,     1'b0, 64'h0,        64'h0,          ONES, 2'd0, 1'b1, 8'd8},  // R8 oversize count
    '{5'd12, 7'd100, 64'h3_F000,     1'b1, 64'h3_F000,   64'hFFFF_FFFF_FFFF_F000, M12, 2'd3, 1'b0, 8'd8}, // R8 top entry
    '{5'd12, 7'd64,  64'hFFFF_0000_0000_0000, 1'b0, 64'h0, 64'h0,        ONES, 2'd0, 1'b1, 8'd4}   // R4 high bits
  };

  logic          clk;
  logic          rst_n;
  logic [SW-1:0] cfg_page_shift;
  logic [CW-1:0] cfg_entry_count;
  logic          tbl_wr_en;
  logic [IW-1:0] tbl_wr_idx;
  logic [AW-1:0] tbl_wr_data;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic          req_write;
  logic          rsp_valid;
  logic          rsp_ready;
  logic [AW-1:0] rsp_iova;
  logic [AW-1:0] rsp_xlate;
  logic [AW-1:0] rsp_mask;
  logic [1:0]    rsp_perm;
  logic          rsp_fault;

  io_page_xlate dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_page_shift(cfg_page_shift), .cfg_entry_count(cfg_entry_count),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_data(tbl_wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_iova(rsp_iova), .rsp_xlate(rsp_xlate), .rsp_mask(rsp_mask),
    .rsp_perm(rsp_perm), .rsp_fault(rsp_fault)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tbl_write(input logic [IW-1:0] idx, input logic [63:0] data);
    @(negedge clk);
    tbl_wr_en = 1'b1; tbl_wr_idx = idx; tbl_wr_data = data;
    @(negedge clk);
    tbl_wr_en = 1'b0;
  endtask

  // Issue one lookup and leave the response visible at the following negedge.
  task automatic lookup(input logic [4:0] sh, input logic [6:0] cnt,
                        input logic [63:0] a, input logic w);
    @(negedge clk);
    cfg_page_shift = sh; cfg_entry_count = cnt;
    req_addr = a; req_write = w; req_valid = 1'b1; rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check_rsp(input string tag, input vec_t v);
    check({tag, " valid"}, 64'(rsp_valid), 64'd1);
    check({tag, " iova"},  rsp_iova,  v.iova);
    check({tag, " xlate"}, rsp_xlate, v.xlate);
    check({tag, " mask"},  rsp_mask,  v.mask);
    check({tag, " perm"},  64'(rsp_perm),  64'(v.perm));
    check({tag, " fault"}, 64'(rsp_fault), 64'(v.fault));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    vec_t e;
    rst_n = 1'b0;
    cfg_page_shift = 5'd12; cfg_entry_count = 7'd64;
    tbl_wr_en = 1'b0; tbl_wr_idx = '0; tbl_wr_data = '0;
    req_valid = 1'b0; req_addr = '0; req_write = 1'b0; rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state at the ports and a cleared table
    check("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check("R1 req_ready after reset", 64'(req_ready), 64'd1);
    lookup(5'd12, 7'd64, 64'h5123, 1'b0);
    e = '{5'd12, 7'd64, 64'h5123, 1'b0, 64'h5000, 64'h0, M12, 2'd0, 1'b1, 8'd1};
    check_rsp("R1 empty entry", e);

    // Preload the table through the update port
    tbl_write(6'd0,  64'h0000_0000_1234_5003);
    tbl_write(6'd1,  64'h0000_0000_ABCD_E001);
    tbl_write(6'd2,  64'h0000_0000_0055_5002);
    tbl_write(6'd3,  64'h0000_0000_0077_7000);
    tbl_write(6'd63, 64'hFFFF_FFFF_FFFF_FFFF);

    // Vector walk
    for (int i = 0; i < NV; i++) begin
      lookup(VECS[i].shift, VECS[i].count, VECS[i].addr, VECS[i].wr);
      check_rsp($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i]);
    end

    // R9: back-pressure holds the response and blocks new requests
    @(negedge clk);
    cfg_page_shift = 5'd12; cfg_entry_count = 7'd64;
    rsp_ready = 1'b0; req_valid = 1'b1; req_addr = 64'h0010; req_write = 1'b0;
    @(negedge clk);
    check("R9 valid after accept", 64'(rsp_valid), 64'd1);
    check("R9 ready low while stalled", 64'(req_ready), 64'd0);
    req_addr = 64'h1010;
    @(negedge clk);
    check("R9 held valid", 64'(rsp_valid), 64'd1);
    check("R9 held xlate", rsp_xlate, 64'h1234_5000);
    check("R9 held perm", 64'(rsp_perm), 64'd3);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 second valid", 64'(rsp_valid), 64'd1);
    check("R9 second iova", rsp_iova, 64'h1000);
    check("R9 second perm", 64'(rsp_perm), 64'd1);
    @(negedge clk);
    check("R9 drained", 64'(rsp_valid), 64'd0);

    // R10: write and lookup to the same entry on one edge
    @(negedge clk);
    tbl_wr_en = 1'b1; tbl_wr_idx = 6'd5; tbl_wr_data = 64'h0000_0000_0000_9003;
    req_valid = 1'b1; req_addr = 64'h5000; req_write = 1'b0; rsp_ready = 1'b1;
    @(negedge clk);
    tbl_wr_en = 1'b0; req_valid = 1'b0;
    check("R10 same-edge old perm", 64'(rsp_perm), 64'd0);
    check("R10 same-edge old xlate", rsp_xlate, 64'h0);
    lookup(5'd12, 7'd64, 64'h5000, 1'b1);
    check("R10 later new perm", 64'(rsp_perm), 64'd3);
    check("R10 later new xlate", rsp_xlate, 64'h9000);

    // R1: a second reset clears the table again
    do_reset();
    check("R1 valid after re-reset", 64'(rsp_valid), 64'd0);
    lookup(5'd12, 7'd64, 64'h0ABC, 1'b0);
    e = '{5'd12, 7'd64, 64'h0ABC, 1'b0, 64'h0, 64'h0, M12, 2'd0, 1'b1, 8'd1};
    check_rsp("R1 cleared entry", e);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule